// File: doc/BRIEF.md
# PHY control-register access bridge

This block gives a host on a simple 32-bit register bus access to the 16-bit control-register space inside a serial PHY. The access is indirect. The host puts a value into a shared data-in register. It then fires one of four commands: latch that value as the PHY address, latch it as the write data, fetch the addressed PHY register, or store the latched data into it. Each command is fired by a self-clearing trigger bit.

Each command becomes one request on a synchronous request/acknowledge port toward the PHY. The request carries a 2-bit command code, the latched 16-bit address and the latched 16-bit write data. The trigger bit reads as 1 while the command is in flight, so the host polls it. A fetched value is kept in a data-out register until the next fetch completes. Per-lane PHY registers are placed at a lane base plus 0x100 times the lane number, for example 0x1002 and 0x1006 for lane 0. Because of this, one address latch often serves several stores and fetches in a row.

Top module: `phyreg_bridge`

## Requirements
- R1: Host offsets: data-in 0x0C, data-out 0x10, and triggers for latch-address 0x14, latch-data 0x18, fetch 0x1C and store 0x20. After reset every host register reads zero, and `phy_req` is low throughout reset.
- R2: A host write to data-in stores all 32 bits, and a read of data-in returns them unchanged.
- R3: Writing 1 to bit 0 of the latch-address trigger copies bits 15:0 of data-in into the address latch. It then issues a request with command code 0, with `phy_addr` showing the new address and `phy_wdata` the current write-data latch.
- R4: Writing 1 to bit 0 of the latch-data trigger copies bits 15:0 of data-in into the write-data latch. It then issues a request with command code 1, carrying the current address latch and the new data.
- R5: A trigger reads 1 in bit 0 and 0 in bits 31:1 from the cycle after it is written until the cycle after acknowledge is sampled. Then it reads 0. With an acknowledge that arrives L+1 cycles after the request rises, the trigger reads 1 for exactly L+3 consecutive cycles.
- R6: While `phy_req` is high and `phy_ack` is low, the request and its command, address and data stay unchanged. `phy_req` falls in the cycle after acknowledge.
- R7: The store trigger issues a request with command code 3 carrying the address and write-data latches. The PHY register at that address then holds the write data.
- R8: The fetch trigger issues a request with command code 2. The value on `phy_rdata` at acknowledge goes into data-out, which reads it in bits 15:0 and zero in bits 31:16. The first fetch is correct. Data-out keeps its value through other commands and host writes until the next fetch completes.
- R9: Any trigger written while a command is busy is ignored. No request is issued for it, its trigger reads 0, neither latch changes, and the busy command finishes unaffected.
- R10: A write to a trigger offset with bit 0 clear starts nothing. The trigger reads 0 and no request is issued.
- R11: Both latches keep their values across commands until their own trigger overwrites them. A store or fetch with no fresh latch command reuses the last address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | Host access strobe for this cycle |
| host_wr | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (valid in the cycle of a read access) |
| phy_req | output | 1 | Request toward the PHY, held until acknowledged |
| phy_cmd | output | 2 | Command code: 0 latch address, 1 latch data, 2 fetch, 3 store |
| phy_addr | output | 16 | Address latch |
| phy_wdata | output | 16 | Write-data latch |
| phy_ack | input | 1 | Acknowledge from the PHY, one cycle |
| phy_rdata | input | 16 | Fetch result, valid with acknowledge |

## Verification
The store and fetch sequences run against a PHY register model at acknowledge latencies of 0, 1, 3 and 6 cycles. The exact busy length of each trigger shows whether a trigger clears one cycle late or early. The same sequences also cover addresses in two lanes and words that share low bits, which separates a correct address latch from one that drops bits or aliases lanes. Store and fetch without a fresh latch command show whether the latches persist. Upper-half junk in data-in shows that only the low 16 bits are used. Triggers fired while another command is busy, writes with bit 0 clear, and writes to data-out are checked against the request stream and data-out, so any ignored action that leaks out is seen.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;

   // command codes carried on phy_cmd; index also selects the trigger slot
   typedef enum logic [1:0] {
      CMD_LATCH_ADDR = 2'd0,
      CMD_LATCH_DATA = 2'd1,
      CMD_FETCH      = 2'd2,
      CMD_STORE      = 2'd3
   } phy_cmd_e;

   localparam int NCMD = 4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_DONE = 2'd2
   } seq_state_e;

endpackage

// File: rtl/phyreg_hostregs.sv
module phyreg_hostregs
   import phyreg_pkg::*;
#(
   parameter int BUS_AW      = 8,
   parameter int BUS_DW      = 32,
   parameter int PHY_DW      = 16,
   parameter int OFS_DIN     = 'h0C,
   parameter int OFS_DOUT    = 'h10,
   parameter int OFS_TRIG    = 'h14,
   parameter int TRIG_STRIDE = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic [BUS_AW-1:0] host_addr,
   input  logic [BUS_DW-1:0] host_wdata,
   output logic [BUS_DW-1:0] host_rdata,
   output logic [BUS_DW-1:0] din,
   output logic [NCMD-1:0]   fire,
   input  logic [NCMD-1:0]   busy,
   input  logic [PHY_DW-1:0] dout
);

   localparam logic [BUS_AW-1:0] A_DIN  = BUS_AW'(OFS_DIN);
   localparam logic [BUS_AW-1:0] A_DOUT = BUS_AW'(OFS_DOUT);

   logic              wr_stb;
   logic              rd_stb;
   logic [NCMD-1:0]   hit_trig;
   logic [BUS_DW-1:0] trig_rd [NCMD];

   assign wr_stb = host_sel & host_wr;
   assign rd_stb = host_sel & ~host_wr;

   always_ff @(posedge clk) begin
      if (rst) begin
         din <= '0;
      end else if (wr_stb && host_addr == A_DIN) begin
         din <= host_wdata;
      end
   end

   // one trigger slot per command, laid out at a fixed stride
   for (genvar i = 0; i < NCMD; i++) begin : g_trig
      localparam logic [BUS_AW-1:0] A_TRIG = BUS_AW'(OFS_TRIG + i * TRIG_STRIDE);
      assign hit_trig[i] = (host_addr == A_TRIG);
      assign fire[i]     = wr_stb & hit_trig[i] & host_wdata[0];
      assign trig_rd[i]  = BUS_DW'(busy[i]);
   end

   always_comb begin
      host_rdata = '0;
      if (rd_stb) begin
         if (host_addr == A_DIN) begin
            host_rdata = din;
         end
         if (host_addr == A_DOUT) begin
            host_rdata = BUS_DW'(dout);
         end
         for (int i = 0; i < NCMD; i++) begin
            if (hit_trig[i]) begin
               host_rdata = trig_rd[i];
            end
         end
      end
   end

endmodule

// File: rtl/phyreg_seq.sv
module phyreg_seq
   import phyreg_pkg::*;
#(
   parameter int PHY_AW = 16,
   parameter int PHY_DW = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NCMD-1:0]   fire,
   input  logic [PHY_AW-1:0] din_addr,
   input  logic [PHY_DW-1:0] din_data,
   output logic [NCMD-1:0]   busy,
   output logic [PHY_DW-1:0] rd_hold,
   output logic              phy_req,
   output logic [1:0]        phy_cmd,
   output logic [PHY_AW-1:0] phy_addr,
   output logic [PHY_DW-1:0] phy_wdata,
   input  logic              phy_ack,
   input  logic [PHY_DW-1:0] phy_rdata
);

   seq_state_e        st;
   phy_cmd_e          cmd_q;
   logic [PHY_AW-1:0] addr_q;
   logic [PHY_DW-1:0] wd_q;

   // lowest set trigger wins; a single host write only ever sets one
   function automatic phy_cmd_e pick(input logic [NCMD-1:0] f);
      phy_cmd_e c;
      c = CMD_LATCH_ADDR;
      for (int i = NCMD - 1; i >= 0; i--) begin
         if (f[i]) begin
            c = phy_cmd_e'(2'(i));
         end
      end
      return c;
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= ST_IDLE;
         cmd_q   <= CMD_LATCH_ADDR;
         busy    <= '0;
         addr_q  <= '0;
         wd_q    <= '0;
         rd_hold <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (|fire) begin
                  cmd_q <= pick(fire);
                  busy  <= NCMD'(1) << pick(fire);
                  st    <= ST_REQ;
                  if (pick(fire) == CMD_LATCH_ADDR) begin
                     addr_q <= din_addr;
                  end
                  if (pick(fire) == CMD_LATCH_DATA) begin
                     wd_q <= din_data;
                  end
               end
            end
            ST_REQ: begin
               if (phy_ack) begin
                  st <= ST_DONE;
                  if (cmd_q == CMD_FETCH) begin
                     rd_hold <= phy_rdata;
                  end
               end
            end
            ST_DONE: begin
               busy <= '0;
               st   <= ST_IDLE;
            end
            default: begin
               busy <= '0;
               st   <= ST_IDLE;
            end
         endcase
      end
   end

   assign phy_req   = (st == ST_REQ);
   assign phy_cmd   = cmd_q;
   assign phy_addr  = addr_q;
   assign phy_wdata = wd_q;

endmodule

// File: rtl/phyreg_bridge.sv
module phyreg_bridge
   import phyreg_pkg::*;
#(
   parameter int BUS_AW      = 8,
   parameter int BUS_DW      = 32,
   parameter int PHY_AW      = 16,
   parameter int PHY_DW      = 16,
   parameter int OFS_DIN     = 'h0C,
   parameter int OFS_DOUT    = 'h10,
   parameter int OFS_TRIG    = 'h14,
   parameter int TRIG_STRIDE = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic [BUS_AW-1:0] host_addr,
   input  logic [BUS_DW-1:0] host_wdata,
   output logic [BUS_DW-1:0] host_rdata,
   output logic              phy_req,
   output logic [1:0]        phy_cmd,
   output logic [PHY_AW-1:0] phy_addr,
   output logic [PHY_DW-1:0] phy_wdata,
   input  logic              phy_ack,
   input  logic [PHY_DW-1:0] phy_rdata
);

   localparam int TRIG_END = OFS_TRIG + NCMD * TRIG_STRIDE;

   if (PHY_AW > BUS_DW || PHY_DW > BUS_DW) begin : g_bad_width
      $error("PHY address and data must fit in the host data word");
   end
   if (TRIG_STRIDE < 1 || TRIG_END > (1 << BUS_AW)) begin : g_bad_trig
      $error("trigger slots do not fit the host address space");
   end
   if (OFS_DIN == OFS_DOUT) begin : g_bad_dio
      $error("data-in and data-out offsets collide");
   end
   if ((OFS_DIN >= OFS_TRIG && OFS_DIN < TRIG_END) ||
       (OFS_DOUT >= OFS_TRIG && OFS_DOUT < TRIG_END)) begin : g_bad_overlap
      $error("data register offset falls inside the trigger slots");
   end

   logic [BUS_DW-1:0] din_q;
   logic [NCMD-1:0]   fire;
   logic [NCMD-1:0]   busy_vec;
   logic [PHY_DW-1:0] dout_q;

   phyreg_hostregs #(
      .BUS_AW      (BUS_AW),
      .BUS_DW      (BUS_DW),
      .PHY_DW      (PHY_DW),
      .OFS_DIN     (OFS_DIN),
      .OFS_DOUT    (OFS_DOUT),
      .OFS_TRIG    (OFS_TRIG),
      .TRIG_STRIDE (TRIG_STRIDE)
   ) i_regs (
      .clk        (clk),
      .rst        (rst),
      .host_sel   (host_sel),
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .din        (din_q),
      .fire       (fire),
      .busy       (busy_vec),
      .dout       (dout_q)
   );

   phyreg_seq #(
      .PHY_AW (PHY_AW),
      .PHY_DW (PHY_DW)
   ) i_seq (
      .clk       (clk),
      .rst       (rst),
      .fire      (fire),
      .din_addr  (din_q[PHY_AW-1:0]),
      .din_data  (din_q[PHY_DW-1:0]),
      .busy      (busy_vec),
      .rd_hold   (dout_q),
      .phy_req   (phy_req),
      .phy_cmd   (phy_cmd),
      .phy_addr  (phy_addr),
      .phy_wdata (phy_wdata),
      .phy_ack   (phy_ack),
      .phy_rdata (phy_rdata)
   );

endmodule

// File: rtl/phyreg_bridge_chk.sv
module phyreg_bridge_chk
   import phyreg_pkg::*;
#(
   parameter int PHY_AW = 16,
   parameter int PHY_DW = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              phy_req,
   input logic              phy_ack,
   input logic [1:0]        phy_cmd,
   input logic [PHY_AW-1:0] phy_addr,
   input logic [PHY_DW-1:0] phy_wdata,
   input logic [NCMD-1:0]   trig_busy,
   input logic [PHY_DW-1:0] dout
);

   p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (phy_req && !phy_ack) |=> (phy_req && $stable(phy_cmd) &&
                                 $stable(phy_addr) && $stable(phy_wdata)));

   p_ack_drop_r6: assert property (@(posedge clk) disable iff (rst)
      (phy_req && phy_ack) |=> !phy_req);

   p_one_busy_r9: assert property (@(posedge clk) disable iff (rst)
      $onehot0(trig_busy));

   p_req_owner_r5: assert property (@(posedge clk) disable iff (rst)
      phy_req |-> trig_busy[phy_cmd]);

   p_dout_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !(phy_req && phy_ack && phy_cmd == 2'(CMD_FETCH)) |=> $stable(dout));

endmodule

bind phyreg_bridge phyreg_bridge_chk #(
   .PHY_AW (PHY_AW),
   .PHY_DW (PHY_DW)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .phy_req   (phy_req),
   .phy_ack   (phy_ack),
   .phy_cmd   (phy_cmd),
   .phy_addr  (phy_addr),
   .phy_wdata (phy_wdata),
   .trig_busy (busy_vec),
   .dout      (dout_q)
);

// File: tb/test_phyreg_bridge.sv
// PHY register-space model: acts on its own copies of address and data
module phyreg_phy_model (
   input  logic        clk,
   input  logic        rst,
   input  logic        req,
   input  logic [1:0]  cmd,
   input  logic [15:0] addr,
   input  logic [15:0] wdata,
   input  logic [3:0]  lat,
   output logic        ack,
   output logic [15:0] rdata
);
   logic [15:0] mem [64];
   logic [15:0] a_q;
   logic [15:0] d_q;
   logic [3:0]  cnt;

   function automatic int idx(input logic [15:0] a);
      return int'({a[8], a[4:0]});
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         ack   <= 1'b0;
         cnt   <= '0;
         a_q   <= '0;
         d_q   <= '0;
         rdata <= '0;
         for (int i = 0; i < 64; i++) mem[i] <= 16'(16'h3C00 ^ (i * 16'h0111));
      end else if (ack) begin
         ack <= 1'b0;
      end else if (req) begin
         if (cnt == lat) begin
            ack <= 1'b1;
            cnt <= '0;
            case (cmd)
               2'd0: a_q <= addr;
               2'd1: d_q <= wdata;
               2'd2: rdata <= mem[idx(a_q)];
               default: mem[idx(a_q)] <= d_q;
            endcase
         end else begin
            cnt <= cnt + 4'd1;
         end
      end
   end
endmodule

module test_phyreg_bridge;
   localparam int HALF = 4;
   localparam logic [7:0] A_DIN = 8'h0C, A_DOUT = 8'h10;
   localparam logic [7:0] A_TLA = 8'h14, A_TLD = 8'h18, A_TFE = 8'h1C, A_TST = 8'h20;

   typedef struct packed {
      logic [1:0]  cmd;
      logic [15:0] a;
      logic [15:0] d;
   } item_t;

   logic        clk = 0;
   logic        rst = 1;
   logic        host_sel = 0, host_wr = 0;
   logic [7:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        phy_req, phy_ack;
   logic [1:0]  phy_cmd;
   logic [15:0] phy_addr, phy_wdata, phy_rdata;
   logic [3:0]  lat = 4'd0;

   int n_chk = 0, n_fail = 0, n_tx = 0;
   item_t exp_q [$];
   logic [15:0] shadow [64];
   logic [15:0] exp_a = '0, exp_wd = '0;

   always #HALF clk = ~clk;

   phyreg_bridge i_phyreg_bridge (
      .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .phy_req(phy_req), .phy_cmd(phy_cmd), .phy_addr(phy_addr),
      .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
   );

   phyreg_phy_model i_model (
      .clk(clk), .rst(rst), .req(phy_req), .cmd(phy_cmd), .addr(phy_addr),
      .wdata(phy_wdata), .lat(lat), .ack(phy_ack), .rdata(phy_rdata)
   );

   function automatic int idx(input logic [15:0] a);
      return int'({a[8], a[4:0]});
   endfunction

   function automatic string tag_of(input logic [1:0] c);
      case (c)
         2'd0: return "R3";
         2'd1: return "R4";
         2'd2: return "R8";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic host_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_sel = 0; host_wr = 0;
   endtask

   task automatic host_read(input logic [7:0] a, output logic [31:0] d);
      host_sel = 1; host_wr = 0; host_addr = a;
      #1 d = host_rdata;
      host_sel = 0;
   endtask

   task automatic poll(input logic [7:0] a, output int ones);
      logic [31:0] v;
      ones = 0;
      for (int k = 0; k < 1000; k++) begin
         host_read(a, v);
         if (k == 0) chk(v[31:1] == 0, "R5", "trigger upper bits", 64'(v), 64'(v[0]));
         if (!v[0]) break;
         ones++;
         @(negedge clk);
      end
   endtask

   task automatic fire_op(input logic [7:0] t, input logic [1:0] c);
      int ones;
      exp_q.push_back('{cmd: c, a: exp_a, d: exp_wd});
      host_write(t, 32'h0000_0001);
      poll(t, ones);
      chk(ones == int'(lat) + 3, "R5", "busy cycles", 64'(ones), 64'(int'(lat) + 3));
   endtask

   task automatic op_addr(input logic [15:0] a);
      host_write(A_DIN, {16'hC0DE, a});
      exp_a = a;
      fire_op(A_TLA, 2'd0);
   endtask

   task automatic op_data(input logic [15:0] d);
      host_write(A_DIN, {16'hF00D, d});
      exp_wd = d;
      fire_op(A_TLD, 2'd1);
   endtask

   task automatic op_store();
      shadow[idx(exp_a)] = exp_wd;
      fire_op(A_TST, 2'd3);
   endtask

   task automatic op_fetch(input string rq);
      logic [31:0] v;
      fire_op(A_TFE, 2'd2);
      host_read(A_DOUT, v);
      chk(v == {16'h0, shadow[idx(exp_a)]}, rq, "data-out after fetch",
          64'(v), 64'({16'h0, shadow[idx(exp_a)]}));
   endtask

   // scoreboard monitor: every request cycle is compared with the queue head
   always @(negedge clk) begin
      item_t f;
      if (!rst && phy_req) begin
         if (exp_q.size() == 0) begin
            chk(0, "R9", "unexpected request", 64'({phy_cmd, phy_addr, phy_wdata}), 64'(0));
         end else begin
            f = exp_q[0];
            chk(phy_cmd == f.cmd && phy_addr == f.a && phy_wdata == f.d,
                (phy_ack ? tag_of(f.cmd) : "R6"), "request fields",
                64'({phy_cmd, phy_addr, phy_wdata}), 64'(f));
            if (phy_ack) begin
               void'(exp_q.pop_front());
               n_tx++;
            end
         end
      end
   end

   initial begin
      #(2 * HALF * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, actual 0 expected 1");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] hold;
      int ones;
      int tx0;
      for (int i = 0; i < 64; i++) shadow[i] = 16'(16'h3C00 ^ (i * 16'h0111));

      // R1: reset
      repeat (3) @(negedge clk);
      chk(phy_req == 0, "R1", "phy_req in reset", 64'(phy_req), 64'(0));
      rst = 0;
      @(negedge clk);
      host_read(A_DIN, v);  chk(v == 0, "R1", "data-in reset", 64'(v), 64'(0));
      host_read(A_DOUT, v); chk(v == 0, "R1", "data-out reset", 64'(v), 64'(0));
      host_read(A_TLA, v);  chk(v == 0, "R1", "latch-addr trig reset", 64'(v), 64'(0));
      host_read(A_TLD, v);  chk(v == 0, "R1", "latch-data trig reset", 64'(v), 64'(0));
      host_read(A_TFE, v);  chk(v == 0, "R1", "fetch trig reset", 64'(v), 64'(0));
      host_read(A_TST, v);  chk(v == 0, "R1", "store trig reset", 64'(v), 64'(0));
      chk(phy_req == 0, "R1", "phy_req after reset", 64'(phy_req), 64'(0));

      // R2: data-in full width
      host_write(A_DIN, 32'hA5C3_1E0F);
      host_read(A_DIN, v);
      chk(v == 32'hA5C3_1E0F, "R2", "data-in readback", 64'(v), 64'hA5C3_1E0F);

      // R3 R4 R7 R8: store then fetch, zero latency
      lat = 4'd0;
      op_addr(16'h1002);
      op_data(16'h1234);
      op_store();
      op_fetch("R8");

      // R5 with latency 3, first fetch of an untouched register
      lat = 4'd3;
      op_addr(16'h1006);
      op_fetch("R8");

      // second lane, latency 1
      lat = 4'd1;
      op_addr(16'h1102);
      op_data(16'hBEEF);
      op_store();
      op_fetch("R7");
      op_addr(16'h1002);
      op_fetch("R7");

      // R11: latches persist across commands
      op_addr(16'h102D);
      op_store();
      op_fetch("R11");
      op_data(16'h0F0F);
      op_store();
      op_fetch("R11");

      // R9: triggers during a busy command are ignored
      lat = 4'd6;
      tx0 = n_tx;
      host_write(A_DIN, 32'h0000_1010);
      exp_a = 16'h1010;
      exp_q.push_back('{cmd: 2'd0, a: exp_a, d: exp_wd});
      host_write(A_TLA, 32'h1);
      host_write(A_TFE, 32'h1);
      host_read(A_TFE, v);
      chk(v == 0, "R9", "fetch trig while busy", 64'(v), 64'(0));
      host_write(A_DIN, 32'h0000_7777);
      host_write(A_TLD, 32'h1);
      host_read(A_TLD, v);
      chk(v == 0, "R9", "latch-data trig while busy", 64'(v), 64'(0));
      host_read(A_TLA, v);
      chk(v == 1, "R9", "busy command still running", 64'(v), 64'(1));
      poll(A_TLA, ones);
      repeat (4) @(negedge clk);
      chk(phy_req == 0, "R9", "no extra request", 64'(phy_req), 64'(0));
      chk(n_tx == tx0 + 1, "R9", "transaction count", 64'(n_tx), 64'(tx0 + 1));
      lat = 4'd0;
      op_store();          // write data latch must still be 0x0F0F
      op_fetch("R9");

      // R10: bit 0 clear starts nothing
      tx0 = n_tx;
      host_write(A_TST, 32'hFFFF_FFFE);
      host_read(A_TST, v);
      chk(v == 0, "R10", "store trig after bit0=0", 64'(v), 64'(0));
      @(negedge clk);
      chk(phy_req == 0, "R10", "no request", 64'(phy_req), 64'(0));
      repeat (3) @(negedge clk);
      chk(n_tx == tx0, "R10", "transaction count", 64'(n_tx), 64'(tx0));

      // R8: data-out holds through other commands and host writes
      host_read(A_DOUT, hold);
      host_write(A_DOUT, 32'hFFFF_FFFF);
      host_read(A_DOUT, v);
      chk(v == hold, "R8", "data-out after host write", 64'(v), 64'(hold));
      op_addr(16'h1006);
      op_data(16'h5555);
      host_read(A_DOUT, v);
      chk(v == hold, "R8", "data-out after latch commands", 64'(v), 64'(hold));
      op_store();
      host_read(A_DOUT, v);
      chk(v == hold, "R8", "data-out after store", 64'(v), 64'(hold));
      op_fetch("R8");

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R6", "pending expected requests", 64'(exp_q.size()), 64'(0));
      finish_run();
   end
endmodule